// File: doc/BRIEF.md
# Mailbox Word Loader with Running CRC-16

This block is a small register-mapped mailbox through which a management master fills an internal memory one 32-bit word at a time. The master sets a 32-bit target address as two 16-bit halves and a 32-bit data word as two 16-bit halves. It then writes a command value that commits the word to a simple write-only memory port. After each committed word the internal address moves on by one word, so a whole section can be streamed with a single address setup.

Every committed word also feeds a running CRC-16. The polynomial is 0x1021, the start value is zero, there is no reflection and no final XOR. Each word enters the CRC most significant byte first. After the last word of a section the master reads the 16-bit result and compares it with its own value to confirm the transfer. A command bit clears the accumulator before a new section.

The CRC engine folds a parameterised number of bytes per cycle, one by default. While it works, a busy flag is visible in the command register. Commit commands that arrive while the flag is set are dropped.

Top module: `mbox_crc_loader`

## Requirements
- R1: After reset, mem_we is 0, the CRC reads 0x0000, the busy flag reads 0, and both address halves read 0.
- R2: Writing index 2 sets address bits 31:16 and writing index 3 sets address bits 15:0. Reading the same indices returns the current address halves.
- R3: Writing index 4 sets data bits 31:16 and writing index 5 sets data bits 15:0. A command write (index 0) with bit 0 (execute) and bit 1 (write) both set, while not busy, gives a single-cycle mem_we pulse in the next cycle, carrying the current address and the assembled word.
- R4: A command write with only one of bit 0 and bit 1 set produces no memory write, leaves the CRC unchanged and does not move the address.
- R5: Each committed word advances the internal address by 4, so consecutive commits land on consecutive word addresses.
- R6: The CRC over the committed words uses polynomial 0x1021 with start value 0, no reflection and no final XOR. Each word enters as bits 31:24, then 23:16, then 15:8, then 7:0.
- R7: A command write with bit 2 set, while not busy, resets the CRC to 0x0000. If bits 0 and 1 are also set in the same write, that word is folded in starting from zero.
- R8: With the default of one byte per cycle, the busy flag (bit 8 of a read of index 0) reads 1 for exactly 4 cycles after an accepted commit. A commit written while busy is dropped: no mem_we, no address advance and no CRC change.
- R9: Index 1 returns the accumulated CRC once busy has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational register read data for reg_idx |
| mem_we | output | 1 | Memory write strobe, one cycle per committed word |
| mem_addr | output | 32 | Byte address of the committed word |
| mem_wdata | output | 32 | Committed data word |

## Verification
The memory strobe, address and data are registered, so they are due one clock after the edge that captures the command. The bench drives every register write at a falling edge and samples the port at the next falling edge. Busy rises at that same edge and stays high for four falling-edge samples. The CRC therefore reads its final value only after four more cycles, and the bench reads it only after waiting them out. Register reads are combinational and are sampled shortly after the bench changes the index, while no edge is pending.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam logic [2:0] IDX_CMD    = 3'd0;
   localparam logic [2:0] IDX_CRC    = 3'd1;
   localparam logic [2:0] IDX_ADR_HI = 3'd2;
   localparam logic [2:0] IDX_ADR_LO = 3'd3;
   localparam logic [2:0] IDX_DAT_HI = 3'd4;
   localparam logic [2:0] IDX_DAT_LO = 3'd5;

   localparam int CMD_EXEC_BIT  = 0;
   localparam int CMD_WRITE_BIT = 1;
   localparam int CMD_CLR_BIT   = 2;
   localparam int STAT_BUSY_BIT = 8;

   // One byte folded into a 16-bit MSB-first CRC, no reflection
   function automatic logic [15:0] crc16_fold(input logic [15:0] acc,
                                              input logic [7:0]  b,
                                              input logic [15:0] poly);
      logic [15:0] r;
      r = acc ^ {b, 8'h00};
      for (int i = 0; i < 8; i++) begin
         r = r[15] ? ((r << 1) ^ poly) : (r << 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/mbox_regs.sv
module mbox_regs #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        idx,
   input  logic [WORD_W/2-1:0] wdata,
   input  logic              advance,
   output logic [WORD_W-1:0] addr,
   output logic [WORD_W-1:0] data
);
   import mbox_pkg::*;
   localparam int HALF_W = WORD_W / 2;
   localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

   generate
      if (WORD_W % 16 != 0) begin : g_bad_width
         $error("WORD_W must be a multiple of 16");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         data <= '0;
      end else begin
         if (advance) begin
            addr <= addr + STEP;
         end else if (wr_en && idx == IDX_ADR_HI) begin
            addr[WORD_W-1:HALF_W] <= wdata;
         end else if (wr_en && idx == IDX_ADR_LO) begin
            addr[HALF_W-1:0] <= wdata;
         end
         if (wr_en && idx == IDX_DAT_HI) data[WORD_W-1:HALF_W] <= wdata;
         if (wr_en && idx == IDX_DAT_LO) data[HALF_W-1:0]      <= wdata;
      end
   end
endmodule

// File: rtl/mbox_crc_engine.sv
module mbox_crc_engine #(
   parameter int          WORD_W         = 32,
   parameter int          BYTES_PER_STEP = 1,
   parameter logic [15:0] POLY           = 16'h1021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic [WORD_W-1:0] word,
   output logic [15:0]       crc,
   output logic              busy
);
   import mbox_pkg::*;
   localparam int NBYTES = WORD_W / 8;
   localparam int STEPS  = NBYTES / BYTES_PER_STEP;
   localparam int CNT_W  = $clog2(STEPS + 1);
   localparam int SHIFT  = 8 * BYTES_PER_STEP;

   generate
      if (BYTES_PER_STEP < 1 || NBYTES % BYTES_PER_STEP != 0) begin : g_bad_step
         $error("BYTES_PER_STEP must divide the word byte count");
      end
   endgenerate

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic [15:0]       chain [BYTES_PER_STEP+1];

   assign chain[0] = crc;
   genvar g;
   generate
      for (g = 0; g < BYTES_PER_STEP; g++) begin : g_fold
         assign chain[g+1] = crc16_fold(chain[g], shreg[WORD_W-1-8*g -: 8], POLY);
      end
   endgenerate

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc   <= '0;
         shreg <= '0;
         cnt   <= '0;
      end else if (load || clear) begin
         if (clear) crc <= '0;
         if (load) begin
            shreg <= word;
            cnt   <= CNT_W'(STEPS);
         end
      end else if (busy) begin
         crc   <= chain[BYTES_PER_STEP];
         shreg <= shreg << SHIFT;
         cnt   <= cnt - 1'b1;
      end
   end

   // R8
   load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load);
   // R8
   load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);
   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !busy) |=> crc == 16'h0000);
endmodule

// File: rtl/mbox_crc_loader.sv
module mbox_crc_loader #(
   parameter int          WORD_W         = 32,
   parameter int          BYTES_PER_STEP = 1,
   parameter logic [15:0] POLY           = 16'h1021
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [2:0]          reg_idx,
   input  logic [15:0]         reg_wdata,
   output logic [15:0]         reg_rdata,
   output logic                mem_we,
   output logic [WORD_W-1:0]   mem_addr,
   output logic [WORD_W-1:0]   mem_wdata
);
   import mbox_pkg::*;
   localparam int HALF_W = WORD_W / 2;

   initial begin
      if (HALF_W != 16) $error("register halves must be 16 bits wide");
   end

   logic [WORD_W-1:0] cur_addr, cur_data;
   logic [15:0]       crc;
   logic              busy, cmd_hit, accept, clr;

   assign cmd_hit = reg_wr && reg_idx == IDX_CMD;
   assign accept  = cmd_hit && reg_wdata[CMD_EXEC_BIT] && reg_wdata[CMD_WRITE_BIT] && !busy;
   assign clr     = cmd_hit && reg_wdata[CMD_CLR_BIT] && !busy;

   mbox_regs #(.WORD_W(WORD_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(reg_idx),
      .wdata(reg_wdata), .advance(accept), .addr(cur_addr), .data(cur_data)
   );

   mbox_crc_engine #(.WORD_W(WORD_W), .BYTES_PER_STEP(BYTES_PER_STEP), .POLY(POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .load(accept), .clear(clr),
      .word(cur_data), .crc(crc), .busy(busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= accept;
         if (accept) begin
            mem_addr  <= cur_addr;
            mem_wdata <= cur_data;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_idx)
         IDX_CMD:    reg_rdata[STAT_BUSY_BIT] = busy;
         IDX_CRC:    reg_rdata = crc;
         IDX_ADR_HI: reg_rdata = cur_addr[WORD_W-1:HALF_W];
         IDX_ADR_LO: reg_rdata = cur_addr[HALF_W-1:0];
         IDX_DAT_HI: reg_rdata = cur_data[WORD_W-1:HALF_W];
         IDX_DAT_LO: reg_rdata = cur_data[HALF_W-1:0];
         default:    reg_rdata = '0;
      endcase
   end

   // R3
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
   // R4
   partial_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && !(reg_wdata[CMD_EXEC_BIT] && reg_wdata[CMD_WRITE_BIT])) |=> !mem_we);
   // R8
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && busy) |=> !mem_we);
endmodule

// File: tb/sim_mbox_crc_loader.sv
module sim_mbox_crc_loader;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_idx = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        mem_we;
   logic [31:0] mem_addr, mem_wdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   logic [31:0] mem_model [256];

   always #(CLK_PERIOD/2) clk = ~clk;

   mbox_crc_loader u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   always @(negedge clk) if (mem_we) mem_model[mem_addr[9:2]] <= mem_wdata;

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [31:0] w);
      logic fb;
      for (int i = 31; i >= 0; i--) begin
         fb = c[15] ^ w[i];
         c  = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge, returns at the next one
   task automatic wr(input logic [2:0] idx, input logic [15:0] v);
      reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] idx, output logic [15:0] v);
      reg_idx = idx;
      #1;
      v = reg_rdata;
   endtask

   task automatic set_addr(input logic [31:0] a);
      wr(3'd2, a[31:16]); wr(3'd3, a[15:0]);
   endtask

   task automatic set_data(input logic [31:0] d);
      wr(3'd4, d[31:16]); wr(3'd5, d[15:0]);
   endtask

   task automatic idle4();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R1 mem_we", {31'b0, mem_we}, 32'h0);
      rd(3'd1, v); chk("R1 crc", {16'h0, v}, 32'h0);
      rd(3'd0, v); chk("R1 busy", {16'h0, v}, 32'h0);
      rd(3'd2, v); chk("R1 addr hi", {16'h0, v}, 32'h0);
      rd(3'd3, v); chk("R1 addr lo", {16'h0, v}, 32'h0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      set_addr(32'h3FFE_0000);
      rd(3'd2, v); chk("R2 addr hi", {16'h0, v}, 32'h3FFE);
      rd(3'd3, v); chk("R2 addr lo", {16'h0, v}, 32'h0000);
      set_data(32'hA1B2_C3D4);
      rd(3'd4, v); chk("R3 data hi", {16'h0, v}, 32'hA1B2);
      rd(3'd5, v); chk("R3 data lo", {16'h0, v}, 32'hC3D4);
   endtask

   task automatic t_single();
      logic [15:0] v;
      wr(3'd0, 16'h0007);
      chk("R3 mem_we", {31'b0, mem_we}, 32'h1);
      chk("R3 mem_addr", mem_addr, 32'h3FFE_0000);
      chk("R3 mem_wdata", mem_wdata, 32'hA1B2_C3D4);
      rd(3'd0, v); chk("R8 busy set", {31'b0, v[8]}, 32'h1);
      @(negedge clk);
      chk("R3 one pulse", {31'b0, mem_we}, 32'h0);
      repeat (2) @(negedge clk);
      rd(3'd0, v); chk("R8 busy 4th cycle", {31'b0, v[8]}, 32'h1);
      @(negedge clk);
      rd(3'd0, v); chk("R8 busy clear", {31'b0, v[8]}, 32'h0);
      rd(3'd1, v); chk("R6 R9 crc one word", {16'h0, v}, {16'h0, ref_crc(16'h0, 32'hA1B2_C3D4)});
      rd(3'd3, v); chk("R5 addr advanced", {16'h0, v}, 32'h0004);
   endtask

   task automatic t_burst();
      logic [15:0] v, exp;
      logic [31:0] w;
      exp = 16'h0;
      set_addr(32'h0000_0040);
      wr(3'd0, 16'h0004);
      idle4();
      for (int k = 0; k < 6; k++) begin
         w = 32'h1357_9BDF ^ (32'h0102_0408 * (k + 1)) ^ {k[7:0], 24'h0};
         set_data(w);
         wr(3'd0, 16'h0003);
         chk("R5 burst addr", mem_addr, 32'h40 + 4 * k);
         exp = ref_crc(exp, w);
         idle4();
         chk("R3 burst mem", mem_model[(8'h10 + 8'(k))], w);
      end
      rd(3'd1, v); chk("R6 R9 burst crc", {16'h0, v}, {16'h0, exp});
      // byte order: a word with only the low byte set differs from the high byte alone
      wr(3'd0, 16'h0004); idle4();
      set_data(32'h0000_0001); wr(3'd0, 16'h0003); idle4();
      rd(3'd1, v); chk("R6 byte order", {16'h0, v}, 32'h1021);
   endtask

   task automatic t_partial();
      logic [15:0] v, crc0, a0;
      rd(3'd1, crc0); rd(3'd3, a0);
      set_data(32'hDEAD_BEEF);
      wr(3'd0, 16'h0001);
      chk("R4 exec only", {31'b0, mem_we}, 32'h0);
      wr(3'd0, 16'h0002);
      chk("R4 write only", {31'b0, mem_we}, 32'h0);
      idle4();
      rd(3'd1, v); chk("R4 crc kept", {16'h0, v}, {16'h0, crc0});
      rd(3'd3, v); chk("R4 addr kept", {16'h0, v}, {16'h0, a0});
   endtask

   task automatic t_busy_drop();
      logic [15:0] v;
      set_addr(32'h0000_0100);
      wr(3'd0, 16'h0004); idle4();
      set_data(32'h0BAD_F00D);
      wr(3'd0, 16'h0003);
      set_data(32'h7777_7777);
      wr(3'd0, 16'h0003);
      chk("R8 dropped no write", {31'b0, mem_we}, 32'h0);
      idle4();
      rd(3'd3, v); chk("R8 addr one step", {16'h0, v}, 32'h0104);
      rd(3'd1, v); chk("R8 crc one word", {16'h0, v}, {16'h0, ref_crc(16'h0, 32'h0BAD_F00D)});
   endtask

   task automatic t_clear();
      logic [15:0] v;
      wr(3'd0, 16'h0004);
      rd(3'd1, v); chk("R7 clear", {16'h0, v}, 32'h0);
      set_data(32'hCAFE_0001);
      wr(3'd0, 16'h0003); idle4();
      set_data(32'h1234_5678);
      wr(3'd0, 16'h0007); idle4();
      rd(3'd1, v); chk("R7 clear with write", {16'h0, v}, {16'h0, ref_crc(16'h0, 32'h1234_5678)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_single();
      t_burst();
      t_partial();
      t_busy_drop();
      t_clear();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule